// File: doc/BRIEF.md
# Trace Record Formatter

This block turns one captured transaction-layer packet header into a trace record and streams that record out one 32-bit word per cycle. The header arrives as four header dwords plus an optional prefix dword. A free-running counter inside the block supplies the time field. It is read in the cycle the header is accepted, so the time stored in the record does not depend on how long the downstream side stalls.

A one-bit layout select picks one of two record shapes. The compact layout has four words. Its first word packs the format, type, traffic-class-hint and ordering fields of header dword 0 together with the low 11 bits of the time. The full layout has eight words. It starts with an all-ones signature word, then carries the prefix, the four header dwords unchanged, a zero word and the full time.

The input side and the output side each use a valid/ready handshake. The block holds one record at a time. It does not offer to take a new header until the last word of the current record has been handed over.

Top module: `trace_rec_fmt`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rec_valid` is 0 and `hdr_ready` is 1.
- R2: With `fmt_full`=1 at acceptance, the record has 8 words in this order: 0xFFFFFFFF, prefix, header dwords 0 to 3, 0x00000000, timestamp.
- R3: In a full record whose `pfx_present` was 0 at acceptance, word 1 is 0x00000000 whatever `pfx_dw` held.
- R4: With `fmt_full`=0, the record has 4 words. Word 0 is built as follows, where h = header dword 0: bits 31:30 = h[30:29], 29:25 = h[28:24], 24 = h[23], 23 = h[19], 22 = h[16], 21 = h[13], 20:11 = h[9:0], 10:0 = timestamp[10:0].
- R5: Words 1 to 3 of a compact record are header dwords 1 to 3, unchanged.
- R6: The timestamp counter is 0 in the first cycle after reset and grows by one each clock. The value written into a record is the counter value in the cycle where the `hdr_valid`/`hdr_ready` handshake takes place.
- R7: While `rec_valid` is 1 and `rec_ready` is 0, `rec_word` and `rec_last` stay unchanged and `rec_valid` stays 1.
- R8: `hdr_ready` is 0 from the cycle after acceptance until the final word has been handed over. It is 1 in the next cycle. Headers presented while it is 0 leave the record unchanged and produce no record.
- R9: `rec_last` is 1 only on the final word of a record (word 7 in the full layout, word 3 in the compact layout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Block can take a header |
| hdr_dw0 | input | 32 | Header dword 0 |
| hdr_dw1 | input | 32 | Header dword 1 |
| hdr_dw2 | input | 32 | Header dword 2 |
| hdr_dw3 | input | 32 | Header dword 3 |
| pfx_present | input | 1 | Prefix dword is valid |
| pfx_dw | input | 32 | Prefix dword |
| fmt_full | input | 1 | 1 selects the 8-word layout, 0 the 4-word layout |
| rec_valid | output | 1 | Output word valid |
| rec_ready | input | 1 | Downstream takes the word |
| rec_word | output | 32 | Current record word |
| rec_last | output | 1 | Final word of the record |

## Verification
The hardest case to reach is a new header that is offered while a record is still draining under backpressure. Catching a bad `hdr_ready` needs a valid header sitting on the input at exactly the wrong moment. The bench therefore keeps `hdr_valid` high with a different header for the whole drain and releases it only in the cycle of the final handshake. It then checks that the stored record was not overwritten and that no extra record appears. The timestamp is checked against a cycle counter kept in the bench. Stalled drains also check that the time stored in the record is the value from the acceptance cycle, not from the cycle the word is emitted.

// File: rtl/trf_pkg.sv
package trf_pkg;
   localparam int WORD_W        = 32;
   localparam int FULL_WORDS    = 8;
   localparam int COMPACT_WORDS = 4;
   localparam int IDX_W         = $clog2(FULL_WORDS);
   localparam int STAMP_LSBS    = 11;

   typedef logic [WORD_W-1:0] word_t;
   typedef word_t [FULL_WORDS-1:0] rec_t;
   typedef logic [IDX_W-1:0] idx_t;

   localparam word_t FULL_SIG   = '1;
   localparam idx_t  FULL_LAST  = idx_t'(FULL_WORDS - 1);
   localparam idx_t  SHORT_LAST = idx_t'(COMPACT_WORDS - 1);
endpackage

// File: rtl/trf_stamp.sv
module trf_stamp #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end

   p_stamp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> now == $past(now) + 1'b1);
endmodule

// File: rtl/trf_build.sv
module trf_build
   import trf_pkg::*;
#(
   parameter int TS_W = 32
) (
   input  word_t           h0,
   input  word_t           h1,
   input  word_t           h2,
   input  word_t           h3,
   input  word_t           pfx,
   input  logic            pfx_en,
   input  logic            full,
   input  logic [TS_W-1:0] stamp,
   output rec_t            rec,
   output idx_t            last_idx
);
   word_t stamp_w;

   generate
      if (TS_W >= WORD_W) begin : g_trunc
         assign stamp_w = stamp[WORD_W-1:0];
      end else begin : g_ext
         assign stamp_w = {{(WORD_W-TS_W){1'b0}}, stamp};
      end
   endgenerate

   always_comb begin
      rec = '0;
      if (full) begin
         rec[0]   = FULL_SIG;
         rec[1]   = pfx_en ? pfx : '0;
         rec[2]   = h0;
         rec[3]   = h1;
         rec[4]   = h2;
         rec[5]   = h3;
         rec[6]   = '0;
         rec[7]   = stamp_w;
         last_idx = FULL_LAST;
      end else begin
         rec[0]   = {h0[30:29], h0[28:24], h0[23], h0[19], h0[16], h0[13],
                     h0[9:0], stamp_w[STAMP_LSBS-1:0]};
         rec[1]   = h1;
         rec[2]   = h2;
         rec[3]   = h3;
         last_idx = SHORT_LAST;
      end
   end
endmodule

// File: rtl/trf_drain.sv
module trf_drain
   import trf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  rec_t  rec_in,
   input  idx_t  last_in,
   output logic  busy,
   output logic  valid,
   input  logic  ready,
   output word_t word,
   output logic  last
);
   rec_t store;
   idx_t idx;
   idx_t last_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store    <= '0;
         idx      <= '0;
         last_idx <= '0;
         busy     <= 1'b0;
      end else if (load) begin
         store    <= rec_in;
         idx      <= '0;
         last_idx <= last_in;
         busy     <= 1'b1;
      end else if (busy && ready) begin
         if (idx == last_idx) busy <= 1'b0;
         else                 idx  <= idx + 1'b1;
      end
   end

   assign valid = busy;
   assign word  = store[idx];
   assign last  = busy && (idx == last_idx);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(word) && $stable(last));
   p_sig_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid && idx == '0 && last_idx == FULL_LAST |-> word == FULL_SIG);
   p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> valid);
endmodule

// File: rtl/trace_rec_fmt.sv
module trace_rec_fmt
   import trf_pkg::*;
#(
   parameter int TS_W = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hdr_valid,
   output logic        hdr_ready,
   input  logic [31:0] hdr_dw0,
   input  logic [31:0] hdr_dw1,
   input  logic [31:0] hdr_dw2,
   input  logic [31:0] hdr_dw3,
   input  logic        pfx_present,
   input  logic [31:0] pfx_dw,
   input  logic        fmt_full,
   output logic        rec_valid,
   input  logic        rec_ready,
   output logic [31:0] rec_word,
   output logic        rec_last
);
   generate
      if (TS_W < STAMP_LSBS) begin : g_bad_ts
         $error("TS_W must cover the compact time field");
      end
   endgenerate

   logic [TS_W-1:0] ts_now;
   rec_t            rec_nxt;
   idx_t            last_nxt;
   logic            busy;
   logic            load;

   assign hdr_ready = !busy;
   assign load      = hdr_valid && hdr_ready;

   trf_stamp #(.TS_W(TS_W)) u_stamp (
      .clk(clk), .rst_n(rst_n), .now(ts_now));

   trf_build #(.TS_W(TS_W)) u_build (
      .h0(hdr_dw0), .h1(hdr_dw1), .h2(hdr_dw2), .h3(hdr_dw3),
      .pfx(pfx_dw), .pfx_en(pfx_present), .full(fmt_full),
      .stamp(ts_now), .rec(rec_nxt), .last_idx(last_nxt));

   trf_drain u_drain (
      .clk(clk), .rst_n(rst_n), .load(load), .rec_in(rec_nxt),
      .last_in(last_nxt), .busy(busy), .valid(rec_valid),
      .ready(rec_ready), .word(rec_word), .last(rec_last));

   p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && rec_ready && rec_last |=> !rec_valid && hdr_ready);
   p_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid && !(rec_ready && rec_last) |=> !hdr_ready);
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready |=> rec_valid && !hdr_ready);
endmodule

// File: tb/sim_trace_rec_fmt.sv
`timescale 1ns/1ps
module sim_trace_rec_fmt;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hdr_valid = 1'b0;
   logic hdr_ready;
   logic [31:0] hdr_dw0 = '0, hdr_dw1 = '0, hdr_dw2 = '0, hdr_dw3 = '0;
   logic pfx_present = 1'b0;
   logic [31:0] pfx_dw = '0;
   logic fmt_full = 1'b0;
   logic rec_valid;
   logic rec_ready = 1'b0;
   logic [31:0] rec_word;
   logic rec_last;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;
   logic [31:0] tb_cyc;

   always #2.5 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) tb_cyc <= '0;
      else        tb_cyc <= tb_cyc + 1;

   trace_rec_fmt u0 (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
      .hdr_dw0(hdr_dw0), .hdr_dw1(hdr_dw1), .hdr_dw2(hdr_dw2), .hdr_dw3(hdr_dw3),
      .pfx_present(pfx_present), .pfx_dw(pfx_dw), .fmt_full(fmt_full),
      .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_word(rec_word),
      .rec_last(rec_last));

   localparam logic [31:0] V_H0 [6] = '{32'h6000_0001, 32'h4A88_2005, 32'h0000_0000,
                                         32'hFFFF_FFFF, 32'h2B91_23FF, 32'h7E08_A1C3};
   localparam logic [31:0] V_H1 [6] = '{32'h0F1E_0001, 32'h1234_5678, 32'hDEAD_BEEF,
                                         32'h0000_0000, 32'hA5A5_5A5A, 32'h0101_0101};
   localparam logic [31:0] V_H2 [6] = '{32'h0400_0000, 32'h9ABC_DEF0, 32'hCAFE_F00D,
                                         32'hFFFF_0000, 32'h3C3C_C3C3, 32'h8080_8080};
   localparam logic [31:0] V_H3 [6] = '{32'h4000_8102, 32'h0BAD_F00D, 32'h1357_9BDF,
                                         32'h0000_FFFF, 32'h0F0F_F0F0, 32'h2468_ACE0};
   localparam logic [31:0] V_PF [6] = '{32'h9100_0042, 32'h5555_AAAA, 32'h7777_7777,
                                         32'hFFFF_FFFF, 32'h0000_0001, 32'hBEEF_0001};
   localparam logic V_PRES  [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic V_FULL  [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam logic V_STALL [6] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
   localparam logic V_JUNK  [6] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [31:0] h0, h1, h2, h3, pf,
                                            input logic pres, full, input int k,
                                            input logic [31:0] ts);
      if (full) begin
         case (k)
            0: return 32'hFFFF_FFFF;
            1: return pres ? pf : 32'h0;
            2: return h0;
            3: return h1;
            4: return h2;
            5: return h3;
            6: return 32'h0;
            default: return ts;
         endcase
      end
      case (k)
         0: return {h0[30:29], h0[28:24], h0[23], h0[19], h0[16], h0[13], h0[9:0], ts[10:0]};
         1: return h1;
         2: return h2;
         default: return h3;
      endcase
   endfunction

   task automatic run_rec(input int i);
      logic [31:0] ts;
      logic [31:0] ew;
      logic [31:0] prev;
      logic tog;
      logic stalled;
      int n;
      int k;
      string tag;
      @(negedge clk);
      check(hdr_ready === 1'b1, "R8", {31'b0, hdr_ready}, 32'h1);
      hdr_dw0 = V_H0[i]; hdr_dw1 = V_H1[i]; hdr_dw2 = V_H2[i]; hdr_dw3 = V_H3[i];
      pfx_dw = V_PF[i]; pfx_present = V_PRES[i]; fmt_full = V_FULL[i];
      hdr_valid = 1'b1;
      ts = tb_cyc;
      @(negedge clk);
      hdr_valid = V_JUNK[i];
      hdr_dw0 = ~V_H0[i]; hdr_dw1 = ~V_H1[i]; hdr_dw2 = ~V_H2[i]; hdr_dw3 = ~V_H3[i];
      pfx_dw = ~V_PF[i]; pfx_present = ~V_PRES[i]; fmt_full = ~V_FULL[i];
      n = V_FULL[i] ? 8 : 4;
      k = 0; tog = 1'b0; stalled = 1'b0; prev = '0;
      while (k < n) begin
         ew = exp_word(V_H0[i], V_H1[i], V_H2[i], V_H3[i], V_PF[i], V_PRES[i],
                       V_FULL[i], k, ts);
         if (V_FULL[i]) tag = (k == 7) ? "R6" : (k == 1 && !V_PRES[i]) ? "R3" : "R2";
         else           tag = (k == 0) ? "R4" : "R5";
         check(rec_valid === 1'b1 && rec_word === ew, tag, rec_word, ew);
         check(rec_last === (k == n-1), "R9", {31'b0, rec_last}, {31'b0, k == n-1});
         if (stalled) check(rec_word === prev, "R7", rec_word, prev);
         if (k != 0 || stalled) check(hdr_ready === 1'b0, "R8", {31'b0, hdr_ready}, 32'h0);
         prev = rec_word;
         rec_ready = V_STALL[i] ? tog : 1'b1;
         tog = ~tog;
         hdr_valid = V_JUNK[i] && (k < n-1 || !rec_ready);
         stalled = !rec_ready;
         if (rec_ready) k++;
         @(negedge clk);
      end
      rec_ready = 1'b0;
      hdr_valid = 1'b0;
      check(rec_valid === 1'b0 && hdr_ready === 1'b1, "R8",
            {30'b0, rec_valid, hdr_ready}, 32'h1);
      for (int j = 0; j < 2; j++) begin
         @(negedge clk);
         check(rec_valid === 1'b0, "R8", {31'b0, rec_valid}, 32'h0);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(rec_valid === 1'b0 && hdr_ready === 1'b1, "R1",
            {30'b0, rec_valid, hdr_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check(rec_valid === 1'b0 && hdr_ready === 1'b1, "R1",
            {30'b0, rec_valid, hdr_ready}, 32'h1);
      check(tb_cyc == 32'd1, "R6", tb_cyc, 32'd1);
      repeat (5) @(negedge clk);
      for (int i = 0; i < 6; i++) run_rec(i);
      // R6: long idle gap so the compact time field wraps its 11 bits
      repeat (2100) @(negedge clk);
      run_rec(1);
      run_rec(5);
      // R1: reset in the middle of a record drops it
      @(negedge clk);
      hdr_dw0 = V_H0[0]; fmt_full = 1'b1; hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(rec_valid === 1'b0 && hdr_ready === 1'b1, "R1",
            {30'b0, rec_valid, hdr_ready}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check(rec_valid === 1'b0, "R1", {31'b0, rec_valid}, 32'h0);
      run_rec(0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule